// File: doc/BRIEF.md
# Gated Frame-Based Light PWM

This block drives one light-control pin from a fast clock, using a pulse-width pattern that repeats every 64 clock cycles. Each frame starts with a run of high cycles and ends with a run of low cycles. The length of the high run is set by a 6-bit brightness value. The code sets the duty to (value + 1) / 64, so the dimmest setting still lights the pin for one cycle in each frame, and the brightest setting holds the pin high with no low cycle. A separate enable bit is the only way to get a fully dark pin.

Software-side logic writes both settings through a one-cycle synchronous write strobe. A select bit on that strobe picks either the control word or the brightness word. A new brightness value is held as pending and only takes over when the current frame ends, so no frame is ever cut short or stretched by a write. Clearing the enable bit darkens the pin at once and puts the frame position back to zero. The next enable therefore always starts with a complete frame.

Top module: `light_pwm_top`

## Requirements
- R1: Synchronous active-high reset clears the enable bit, sets the brightness value to 0 and sets the frame position to 0. After reset `pwm_out` is low, and enabling without first writing a brightness value gives a 1/64 duty.
- R2: While enabled, the output pattern repeats with a period of exactly 64 clock cycles.
- R3: With enable set and brightness L in 0..63, each frame has L+1 high cycles followed by 63-L low cycles. The high cycles come first.
- R4: Brightness 63 gives a continuously high output with no low cycle.
- R5: Brightness 0 with enable set gives exactly one high cycle per frame, not a dark output.
- R6: While enable is clear, `pwm_out` stays low whatever the brightness value is.
- R7: A brightness write takes effect at the start of the next frame. This includes a write whose strobe is in the last cycle of a frame: that write governs the frame that starts right after it.
- R8: A write that clears enable forces `pwm_out` low from the next cycle on and resets the frame position to 0. A later enable starts a full frame at its high portion.
- R9: Write encoding: `wr_sel`=0 selects the control word, and only bit 0 (enable) is kept from it. `wr_sel`=1 selects the brightness word, taken from all 6 bits of `wr_data`. A control write changes neither the brightness nor, if enable stays set, the frame timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; one PWM slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | 1 | 0 = control word, 1 = brightness word |
| wr_data | input | 6 | Write data (bit 0 = enable for control writes) |
| pwm_out | output | 1 | Light PWM output |

## Verification
A brightness write and the end of a frame can land in the same cycle. The design must then send the freshly written value into the following frame and neither drop it nor apply it one frame late. The bench aligns to the frame start, counts out exactly 63 slots and strobes a new brightness in the final slot, then counts the high cycles of the next frame against the new value plus one. A mid-frame write is checked too: the remainder of the current frame must keep the old shape before the new duty appears.

// File: rtl/light_pwm_pkg.sv
package light_pwm_pkg;

    typedef enum logic {
        SEL_CTRL  = 1'b0,
        SEL_LEVEL = 1'b1
    } lp_sel_e;

    typedef struct packed {
        logic set_ctrl;
        logic set_level;
    } lp_cmd_t;

    localparam int ENABLE_BIT = 0;

    function automatic lp_cmd_t lp_decode(input logic strobe, input logic sel);
        lp_cmd_t c;
        c.set_ctrl  = strobe && (lp_sel_e'(sel) == SEL_CTRL);
        c.set_level = strobe && (lp_sel_e'(sel) == SEL_LEVEL);
        return c;
    endfunction

endpackage

// File: rtl/lp_regs.sv
module lp_regs
    import light_pwm_pkg::*;
#(
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  lp_cmd_t          cmd,
    input  logic [LVL_W-1:0] wr_data,
    output logic             en_q,
    output logic             en_next,
    output logic [LVL_W-1:0] pend_next
);
    logic [LVL_W-1:0] pend_q;

    always_comb begin
        en_next   = cmd.set_ctrl  ? wr_data[ENABLE_BIT] : en_q;
        pend_next = cmd.set_level ? wr_data : pend_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            pend_q <= '0;
        end else begin
            en_q   <= en_next;
            pend_q <= pend_next;
        end
    end
endmodule

// File: rtl/lp_frame.sv
module lp_frame #(
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_q,
    input  logic             en_next,
    input  logic [LVL_W-1:0] pend_next,
    output logic [LVL_W-1:0] cnt_q,
    output logic [LVL_W-1:0] lvl_act_q
);
    logic last_slot;

    always_comb last_slot = en_q && (cnt_q == {LVL_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            lvl_act_q <= '0;
        end else begin
            if (!en_next || !en_q) cnt_q <= '0;
            else                   cnt_q <= cnt_q + 1'b1;
            if (!en_q || last_slot) lvl_act_q <= pend_next;
        end
    end
endmodule

// File: rtl/lp_compare.sv
module lp_compare #(
    parameter int LVL_W = 6
) (
    input  logic             en_q,
    input  logic [LVL_W-1:0] cnt_q,
    input  logic [LVL_W-1:0] lvl_act_q,
    output logic             pwm_out
);
    always_comb pwm_out = en_q && (cnt_q <= lvl_act_q);
endmodule

// File: rtl/light_pwm_top.sv
module light_pwm_top
    import light_pwm_pkg::*;
#(
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [LVL_W-1:0] wr_data,
    output logic             pwm_out
);
    lp_cmd_t          cmd;
    logic             en_q;
    logic             en_next;
    logic [LVL_W-1:0] pend_next;
    logic [LVL_W-1:0] cnt_q;
    logic [LVL_W-1:0] lvl_act_q;

    always_comb cmd = lp_decode(wr_en, wr_sel);

    lp_regs #(.LVL_W(LVL_W)) u_regs (
        .clk(clk), .rst(rst), .cmd(cmd), .wr_data(wr_data),
        .en_q(en_q), .en_next(en_next), .pend_next(pend_next)
    );

    lp_frame #(.LVL_W(LVL_W)) u_frame (
        .clk(clk), .rst(rst), .en_q(en_q), .en_next(en_next),
        .pend_next(pend_next), .cnt_q(cnt_q), .lvl_act_q(lvl_act_q)
    );

    lp_compare #(.LVL_W(LVL_W)) u_cmp (
        .en_q(en_q), .cnt_q(cnt_q), .lvl_act_q(lvl_act_q), .pwm_out(pwm_out)
    );
endmodule

// File: rtl/light_pwm_chk.sv
module light_pwm_chk #(
    parameter int LVL_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             wr_sel,
    input logic             ctrl_bit,
    input logic             pwm_out,
    input logic             en_q,
    input logic [LVL_W-1:0] cnt_q,
    input logic [LVL_W-1:0] lvl_act_q
);
    p_dark_when_off_r6: assert property (@(posedge clk) disable iff (rst)
        !en_q |-> !pwm_out);

    p_disable_next_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel && !ctrl_bit) |=> (!pwm_out && cnt_q == '0));

    p_frame_opens_high_r3: assert property (@(posedge clk) disable iff (rst)
        (en_q && cnt_q == '0) |-> pwm_out);

    p_full_on_r4: assert property (@(posedge clk) disable iff (rst)
        (en_q && lvl_act_q == {LVL_W{1'b1}}) |-> pwm_out);

    p_slot_step_r2: assert property (@(posedge clk) disable iff (rst)
        (en_q && $past(en_q)) |-> (cnt_q == LVL_W'($past(cnt_q) + 1'b1)));

    p_level_held_r7: assert property (@(posedge clk) disable iff (rst)
        (en_q && $past(en_q) && cnt_q != '0) |-> $stable(lvl_act_q));
endmodule

bind light_pwm_top light_pwm_chk #(.LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .ctrl_bit(wr_data[0]), .pwm_out(pwm_out), .en_q(en_q),
    .cnt_q(cnt_q), .lvl_act_q(lvl_act_q)
);

// File: tb/light_pwm_top_tb_top.sv
module light_pwm_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // {brightness, expected high cycles per frame}
    localparam int VEC [NVEC][2] = '{
        '{0, 1}, '{1, 2}, '{5, 6}, '{31, 32}, '{62, 63}, '{63, 64}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [5:0] wr_data = '0;
    logic       pwm_out;
    int         nchk = 0;
    int         nfail = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    light_pwm_top dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .pwm_out(pwm_out)
    );

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [5:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic grab(input int n, output int highs, output int contig);
        bit seen_low;
        highs = 0; contig = 1; seen_low = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out) begin
                highs++;
                if (seen_low) contig = 0;
            end else begin
                seen_low = 1'b1;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        int h, c, h2, c2;
        string tag;
        steps(3);
        @(negedge clk);
        rst = 1'b0;
        check("R1 output low after reset", int'(pwm_out), 0);
        grab(70, h, c);
        check("R1 dark while disabled after reset", h, 0);
        wr(1'b0, 6'd1);
        grab(64, h, c);
        check("R1 default brightness gives 1/64", h, 1);

        for (int v = 0; v < NVEC; v++) begin
            tag = (VEC[v][0] == 0) ? "R5" : (VEC[v][0] == 63) ? "R4" : "R3";
            wr(1'b0, 6'd0);
            wr(1'b1, 6'(VEC[v][0]));
            wr(1'b0, 6'd1);
            grab(64, h, c);
            grab(64, h2, c2);
            check({tag, " high count"}, h, VEC[v][1]);
            check("R3 high portion first", c, 1);
            check("R2 next frame identical", h2 * 2 + c2, h * 2 + c);
        end

        // R7 mid-frame write
        wr(1'b0, 6'd0); wr(1'b1, 6'd3); wr(1'b0, 6'd1);
        steps(10);
        wr(1'b1, 6'd20);
        grab(53, h, c);
        check("R7 rest of frame keeps old brightness", h, 0);
        grab(64, h, c);
        check("R7 new brightness next frame", h, 21);
        // R7 write in last slot
        steps(63);
        wr(1'b1, 6'd7);
        grab(64, h, c);
        check("R7 last-slot write governs next frame", h, 8);
        // R9 control write keeps brightness and timing
        wr(1'b0, 6'b000011);
        steps(63);
        grab(64, h, c);
        check("R9 control write leaves brightness", h, 8);
        check("R9 control write leaves frame aligned", c, 1);
        // R6 disabled with full brightness
        wr(1'b1, 6'd63);
        steps(63);
        wr(1'b0, 6'd0);
        check("R8 low right after disable", int'(pwm_out), 0);
        grab(64, h, c);
        check("R6 dark while disabled at brightness 63", h, 0);
        // R8 restart
        wr(1'b1, 6'd2); wr(1'b0, 6'd1);
        steps(1);
        wr(1'b0, 6'd0);
        check("R8 low after mid-frame disable", int'(pwm_out), 0);
        wr(1'b0, 6'd1);
        grab(64, h, c);
        check("R8 re-enable starts full frame", h, 3);
        check("R8 re-enable frame starts high", c, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule